// File: doc/BRIEF.md
# Extended-Precision Float to Integer Converter

This block converts one 80-bit extended-precision floating-point operand into a signed 16-bit or 32-bit integer, the work a float-to-integer store performs. The operand has one sign bit, a 15-bit biased exponent (bias 16383) and a 64-bit significand whose top bit is the explicit integer bit. The caller also supplies a size select and a 2-bit rounding mode. The block returns the integer together with a sticky exception status word. All exceptions are treated as masked, so the response to an invalid operation is the integer-indefinite value (the most-negative integer of the selected size).

The central rule is that a result which does not fit the selected size, after rounding, is an invalid operation. It yields the indefinite value and raises the invalid flag. It is never reported as an overflow, and never as a plain inexact result. This rule holds for every combination of low significand bits on large negative operands. A naive truncation of some of those operands looks like the most-negative integer, and the design must not be misled by that.

A request is accepted through a valid/ready handshake. The result is registered and appears one cycle after acceptance. It is held until the consumer takes it.

Top module: `f2i_convert`

## Requirements
- R1: After reset, res_valid_o is 0, status_o is 0 and req_ready_o is 1.
- R2: An in-range value converts exactly. With size32_i=0 the result sits in result_o[15:0] and result_o[31:16] is 0. With size32_i=1 all 32 bits hold the two's-complement result.
- R3: A positive or negative value whose rounded magnitude does not fit yields 0x00008000 (16-bit) or 0x80000000 (32-bit) and sets IE (status bit 0). Status bits 1 to 4 (DE, ZE, OE, UE) and bits 6 to 15 are never set.
- R4: A finite operand with unbiased exponent of 32 or more is invalid for both sizes, whatever its low significand bits hold.
- R5: rnd_mode_i selects the rounding: 00 nearest with ties to even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero.
- R6: The range check uses the rounded value. -2^15 and -2^31 are valid results. A value that rounds beyond the limit is invalid even if its truncation fits.
- R7: NaN, infinity (exponent all ones) and unnormals (nonzero exponent with integer bit 0) give the indefinite value with IE set.
- R8: An in-range inexact result sets PE (status bit 5) and not IE. An invalid result does not set PE.
- R9: Flags are sticky. Each accepted conversion ORs its flags into status_o. flag_clear_i zeroes status_o before that cycle's new flags are ORed in.
- R10: req_ready_o is 1 when no result is held or res_ready_i is 1. An accepted request shows res_valid_o=1 on the next cycle. A held result and res_valid_o stay unchanged while res_ready_i is 0.
- R11: Zero gives 0 with no flags. A nonzero value of magnitude below 1, including denormals, gives 0 or ±1 according to the rounding mode and sets PE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Operand request valid |
| req_ready_o | output | 1 | Block can accept a request |
| operand_i | input | 80 | Extended-precision operand |
| size32_i | input | 1 | 1: 32-bit result, 0: 16-bit result |
| rnd_mode_i | input | 2 | Rounding mode |
| flag_clear_i | input | 1 | Clear sticky status |
| res_valid_o | output | 1 | Result valid |
| res_ready_i | input | 1 | Consumer takes result |
| result_o | output | 32 | Integer result |
| status_o | output | 16 | Sticky exception status |

## Verification
The bound checker watches several rules on every cycle. It confirms that the overflow-type flags and the unused status bits never rise, and that the IE and PE flags persist until a clear. It checks that the upper half of a 16-bit result stays zero. It also checks that NaN, infinity and operands with a very large exponent always produce the indefinite value with IE set, and that a stalled result holds steady. The bench scenarios are needed for the arithmetic itself. These cover each rounding mode's direction and tie handling, and the operands whose rounded value lands just inside or just outside -2^15 and -2^31. They also cover the significand patterns on large negative operands whose truncation mimics the most-negative integer, and the tiny and denormal inputs.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  localparam int EXP_W    = 15;
  localparam int MANT_W   = 64;
  localparam int OPND_W   = 1 + EXP_W + MANT_W;
  localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
  localparam int WIDE_W   = 32;
  localparam int NARROW_W = 16;
  localparam int SH_W     = $clog2(WIDE_W);
  localparam int MAG_W    = WIDE_W + 1;
  localparam int SE_W     = EXP_W + 2;
  localparam int STAT_W   = 16;

  // status bit positions decoded by the status consumer
  localparam int FLG_IE = 0;
  localparam int FLG_DE = 1;
  localparam int FLG_ZE = 2;
  localparam int FLG_OE = 3;
  localparam int FLG_UE = 4;
  localparam int FLG_PE = 5;

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_DOWN = 2'b01,
    RND_UP   = 2'b10,
    RND_ZERO = 2'b11
  } rnd_e;

  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_TINY,
    CLS_NORM,
    CLS_HUGE,
    CLS_SPECIAL
  } cls_e;
endpackage

// File: rtl/f2i_classify.sv
module f2i_classify
  import f2i_pkg::*;
(
  input  logic [OPND_W-1:0] operand_i,
  output logic              sign_o,
  output cls_e              cls_o,
  output logic [SH_W-1:0]   int_sh_o,
  output logic [MANT_W-1:0] mant_o,
  output logic              tiny_round_o,
  output logic              tiny_sticky_o
);
  logic [EXP_W-1:0]       exp_f;
  logic signed [SE_W-1:0] sh;

  assign sign_o = operand_i[OPND_W-1];
  assign exp_f  = operand_i[MANT_W +: EXP_W];
  assign mant_o = operand_i[MANT_W-1:0];
  assign sh     = $signed({2'b00, exp_f}) - $signed(SE_W'(BIAS));

  always_comb begin
    cls_o         = CLS_NORM;
    int_sh_o      = '0;
    tiny_round_o  = 1'b0;
    tiny_sticky_o = 1'b0;
    if (&exp_f) begin
      cls_o = CLS_SPECIAL;
    end else if (exp_f == '0) begin
      // denormals sit far below one half
      if (mant_o == '0) cls_o = CLS_ZERO;
      else begin
        cls_o         = CLS_TINY;
        tiny_sticky_o = 1'b1;
      end
    end else if (!mant_o[MANT_W-1]) begin
      cls_o = CLS_SPECIAL;
    end else if (sh < 0) begin
      cls_o = CLS_TINY;
      if (sh == '1) begin
        tiny_round_o  = 1'b1;
        tiny_sticky_o = |mant_o[MANT_W-2:0];
      end else begin
        tiny_sticky_o = 1'b1;
      end
    end else if (sh >= $signed(SE_W'(WIDE_W))) begin
      cls_o = CLS_HUGE;
    end else begin
      cls_o    = CLS_NORM;
      int_sh_o = sh[SH_W-1:0];
    end
  end
endmodule

// File: rtl/f2i_align_round.sv
module f2i_align_round
  import f2i_pkg::*;
(
  input  cls_e              cls_i,
  input  logic              sign_i,
  input  logic [SH_W-1:0]   int_sh_i,
  input  logic [MANT_W-1:0] mant_i,
  input  logic              tiny_round_i,
  input  logic              tiny_sticky_i,
  input  rnd_e              rnd_i,
  output logic [MAG_W-1:0]  mag_o,
  output logic              inexact_o
);
  logic [WIDE_W-1:0] int_part;
  logic [WIDE_W-1:0] int_base;
  logic [MANT_W-1:0] frac;
  logic [SH_W-1:0]   rsh;
  logic              rnd_bit;
  logic              stk_bit;
  logic              inc;

  assign rsh      = SH_W'(WIDE_W - 1) - int_sh_i;
  assign int_part = mant_i[MANT_W-1 -: WIDE_W] >> rsh;
  assign frac     = mant_i << ({1'b0, int_sh_i} + 1'b1);

  always_comb begin
    int_base = '0;
    rnd_bit  = 1'b0;
    stk_bit  = 1'b0;
    case (cls_i)
      CLS_NORM: begin
        int_base = int_part;
        rnd_bit  = frac[MANT_W-1];
        stk_bit  = |frac[MANT_W-2:0];
      end
      CLS_TINY: begin
        rnd_bit = tiny_round_i;
        stk_bit = tiny_sticky_i;
      end
      default: ;
    endcase
  end

  always_comb begin
    case (rnd_i)
      RND_NEAR: inc = rnd_bit & (stk_bit | int_base[0]);
      RND_DOWN: inc = sign_i & (rnd_bit | stk_bit);
      RND_UP:   inc = !sign_i & (rnd_bit | stk_bit);
      default:  inc = 1'b0;
    endcase
  end

  assign mag_o     = {1'b0, int_base} + MAG_W'(inc);
  assign inexact_o = rnd_bit | stk_bit;
endmodule

// File: rtl/f2i_range_pack.sv
module f2i_range_pack
  import f2i_pkg::*;
(
  input  cls_e              cls_i,
  input  logic              sign_i,
  input  logic [MAG_W-1:0]  mag_i,
  input  logic              inexact_i,
  input  logic              size32_i,
  output logic [WIDE_W-1:0] result_o,
  output logic              ie_o,
  output logic              pe_o
);
  localparam logic [MAG_W-1:0]  LIM_W   = MAG_W'(1) << (WIDE_W - 1);
  localparam logic [MAG_W-1:0]  LIM_N   = MAG_W'(1) << (NARROW_W - 1);
  localparam logic [WIDE_W-1:0] INDEF_W = WIDE_W'(1) << (WIDE_W - 1);
  localparam logic [WIDE_W-1:0] INDEF_N = WIDE_W'(1) << (NARROW_W - 1);

  logic [MAG_W-1:0]  limit;
  logic              over;
  logic              invalid;
  logic [WIDE_W-1:0] val;

  assign limit = size32_i ? LIM_W : LIM_N;
  // negative side may reach the limit itself
  assign over  = sign_i ? (mag_i > limit) : (mag_i >= limit);
  assign invalid = (cls_i == CLS_SPECIAL) || (cls_i == CLS_HUGE) || over;
  assign val   = sign_i ? -mag_i[WIDE_W-1:0] : mag_i[WIDE_W-1:0];

  always_comb begin
    if (invalid)       result_o = size32_i ? INDEF_W : INDEF_N;
    else if (size32_i) result_o = val;
    else               result_o = {{(WIDE_W-NARROW_W){1'b0}}, val[NARROW_W-1:0]};
  end

  assign ie_o = invalid;
  assign pe_o = !invalid && inexact_i;
endmodule

// File: rtl/f2i_convert.sv
module f2i_convert
  import f2i_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [OPND_W-1:0] operand_i,
  input  logic              size32_i,
  input  logic [1:0]        rnd_mode_i,
  input  logic              flag_clear_i,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic [WIDE_W-1:0] result_o,
  output logic [STAT_W-1:0] status_o
);
  logic              sign;
  cls_e              cls;
  logic [SH_W-1:0]   int_sh;
  logic [MANT_W-1:0] mant;
  logic              tiny_round;
  logic              tiny_sticky;
  logic [MAG_W-1:0]  mag;
  logic              inexact;
  logic [WIDE_W-1:0] res_d;
  logic              ie;
  logic              pe;
  logic              accept;
  logic [STAT_W-1:0] stat_new;
  logic [STAT_W-1:0] stat_d;
  logic              res_valid_q;
  logic [WIDE_W-1:0] result_q;
  logic [STAT_W-1:0] status_q;

  f2i_classify u_classify (
    .operand_i     (operand_i),
    .sign_o        (sign),
    .cls_o         (cls),
    .int_sh_o      (int_sh),
    .mant_o        (mant),
    .tiny_round_o  (tiny_round),
    .tiny_sticky_o (tiny_sticky)
  );

  f2i_align_round u_align_round (
    .cls_i         (cls),
    .sign_i        (sign),
    .int_sh_i      (int_sh),
    .mant_i        (mant),
    .tiny_round_i  (tiny_round),
    .tiny_sticky_i (tiny_sticky),
    .rnd_i         (rnd_e'(rnd_mode_i)),
    .mag_o         (mag),
    .inexact_o     (inexact)
  );

  f2i_range_pack u_range_pack (
    .cls_i     (cls),
    .sign_i    (sign),
    .mag_i     (mag),
    .inexact_i (inexact),
    .size32_i  (size32_i),
    .result_o  (res_d),
    .ie_o      (ie),
    .pe_o      (pe)
  );

  assign req_ready_o = !res_valid_q || res_ready_i;
  assign accept      = req_valid_i && req_ready_o;

  always_comb begin
    stat_new         = '0;
    stat_new[FLG_IE] = accept && ie;
    stat_new[FLG_PE] = accept && pe;
    stat_d           = (flag_clear_i ? '0 : status_q) | stat_new;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_q <= 1'b0;
      result_q    <= '0;
      status_q    <= '0;
    end else begin
      res_valid_q <= accept || (res_valid_q && !res_ready_i);
      if (accept) result_q <= res_d;
      status_q <= stat_d;
    end
  end

  assign res_valid_o = res_valid_q;
  assign result_o    = result_q;
  assign status_o    = status_q;
endmodule

// File: rtl/f2i_convert_chk.sv
module f2i_convert_chk
  import f2i_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [EXP_W-1:0]  exp_i,
  input logic              size32_i,
  input logic              flag_clear_i,
  input logic              res_valid_o,
  input logic              res_ready_i,
  input logic [WIDE_W-1:0] result_o,
  input logic [STAT_W-1:0] status_o
);
  localparam logic [WIDE_W-1:0] IND_W = WIDE_W'(1) << (WIDE_W - 1);
  localparam logic [WIDE_W-1:0] IND_N = WIDE_W'(1) << (NARROW_W - 1);
  localparam logic [EXP_W-1:0]  HUGE_EXP = EXP_W'(BIAS + WIDE_W);

  logic acc;
  assign acc = req_valid_i && req_ready_o;

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[FLG_UE:FLG_DE] == '0 && status_o[STAT_W-1:FLG_PE+1] == '0);

  p_narrow_upper_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !size32_i |=> result_o[WIDE_W-1:NARROW_W] == '0);

  p_special_invalid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && (&exp_i) |=> status_o[FLG_IE] &&
      result_o == ($past(size32_i) ? IND_W : IND_N));

  p_huge_invalid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !(&exp_i) && exp_i >= HUGE_EXP |=> status_o[FLG_IE] &&
      result_o == ($past(size32_i) ? IND_W : IND_N));

  p_sticky_ie_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[FLG_IE] && !flag_clear_i |=> status_o[FLG_IE]);

  p_sticky_pe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[FLG_PE] && !flag_clear_i |=> status_o[FLG_PE]);

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clear_i && !acc |=> status_o == '0);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_ready_i |=> res_valid_o && $stable(result_o));

  p_latency_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> res_valid_o);
endmodule

bind f2i_convert f2i_convert_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .exp_i        (operand_i[f2i_pkg::MANT_W +: f2i_pkg::EXP_W]),
  .size32_i     (size32_i),
  .flag_clear_i (flag_clear_i),
  .res_valid_o  (res_valid_o),
  .res_ready_i  (res_ready_i),
  .result_o     (result_o),
  .status_o     (status_o)
);

// File: tb/f2i_convert_bench.sv
`timescale 1ns/1ps
module f2i_convert_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [79:0] operand = '0;
  logic        size32 = 1'b0;
  logic [1:0]  rnd_mode = 2'b00;
  logic        flag_clear = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [31:0] result;
  logic [15:0] status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  f2i_convert u_f2i_convert (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_valid_i  (req_valid),
    .req_ready_o  (req_ready),
    .operand_i    (operand),
    .size32_i     (size32),
    .rnd_mode_i   (rnd_mode),
    .flag_clear_i (flag_clear),
    .res_valid_o  (res_valid),
    .res_ready_i  (res_ready),
    .result_o     (result),
    .status_o     (status)
  );

  typedef struct packed {
    logic [79:0] op;
    logic        sz;
    logic [1:0]  rm;
    logic [31:0] res;
    logic        ie;
    logic        pe;
    logic [3:0]  req;
  } vec_t;

  // rm: 0 nearest-even, 1 down, 2 up, 3 zero; sz: 1 = 32-bit
  localparam int NV = 41;
  localparam vec_t VEC [NV] = '{
    '{80'h3FFF_8000000000000000, 1'b0, 2'd0, 32'h00000001, 1'b0, 1'b0, 4'd2},  // R2 +1
    '{80'h4005_C800000000000000, 1'b1, 2'd0, 32'h00000064, 1'b0, 1'b0, 4'd2},  // R2 +100
    '{80'hC005_C800000000000000, 1'b0, 2'd0, 32'h0000FF9C, 1'b0, 1'b0, 4'd2},  // R2 -100 narrow
    '{80'hC005_C800000000000000, 1'b1, 2'd0, 32'hFFFFFF9C, 1'b0, 1'b0, 4'd2},  // R2 -100 wide
    '{80'h400D_FFFE000000000000, 1'b0, 2'd0, 32'h00007FFF, 1'b0, 1'b0, 4'd6},  // R6 +32767
    '{80'hC00E_8000000000000000, 1'b0, 2'd0, 32'h00008000, 1'b0, 1'b0, 4'd6},  // R6 -2^15 valid
    '{80'h400E_8000000000000000, 1'b0, 2'd0, 32'h00008000, 1'b1, 1'b0, 4'd3},  // R3 +2^15
    '{80'hC00E_8000000000000001, 1'b0, 2'd0, 32'h00008000, 1'b0, 1'b1, 4'd6},  // R6
    '{80'hC00E_8000000000000001, 1'b0, 2'd1, 32'h00008000, 1'b1, 1'b0, 4'd6},  // R6 rounds out
    '{80'hC00E_8000000000000001, 1'b0, 2'd3, 32'h00008000, 1'b0, 1'b1, 4'd6},  // R6
    '{80'hC00F_8000000000000001, 1'b0, 2'd0, 32'h00008000, 1'b1, 1'b0, 4'd4},  // R4 mimic
    '{80'hC00F_8000000000000001, 1'b1, 2'd0, 32'hFFFF0000, 1'b0, 1'b1, 4'd4},  // R4 fits wide
    '{80'hC00F_80000000FFFFFFFF, 1'b0, 2'd0, 32'h00008000, 1'b1, 1'b0, 4'd4},  // R4 low bits
    '{80'hC01F_8000000000000001, 1'b1, 2'd0, 32'h80000000, 1'b1, 1'b0, 4'd4},  // R4 wide mimic
    '{80'hC01E_8000000000000000, 1'b1, 2'd0, 32'h80000000, 1'b0, 1'b0, 4'd6},  // R6 -2^31 valid
    '{80'hC01E_8000000080000000, 1'b1, 2'd0, 32'h80000000, 1'b0, 1'b1, 4'd6},  // R6 tie even
    '{80'hC01E_8000000080000000, 1'b1, 2'd1, 32'h80000000, 1'b1, 1'b0, 4'd6},  // R6 rounds out
    '{80'h401D_FFFFFFFE00000000, 1'b1, 2'd0, 32'h7FFFFFFF, 1'b0, 1'b0, 4'd2},  // R2 max wide
    '{80'h401E_8000000000000000, 1'b1, 2'd0, 32'h80000000, 1'b1, 1'b0, 4'd3},  // R3 +2^31
    '{80'h4000_A000000000000000, 1'b0, 2'd0, 32'h00000002, 1'b0, 1'b1, 4'd5},  // R5 2.5 near
    '{80'h4000_A000000000000000, 1'b0, 2'd2, 32'h00000003, 1'b0, 1'b1, 4'd5},  // R5 2.5 up
    '{80'hC000_A000000000000000, 1'b0, 2'd1, 32'h0000FFFD, 1'b0, 1'b1, 4'd5},  // R5 -2.5 down
    '{80'hC000_A000000000000000, 1'b1, 2'd0, 32'hFFFFFFFE, 1'b0, 1'b1, 4'd5},  // R5 -2.5 near
    '{80'hC000_A000000000000000, 1'b1, 2'd3, 32'hFFFFFFFE, 1'b0, 1'b1, 4'd5},  // R5 -2.5 zero
    '{80'hC000_A000000000000000, 1'b1, 2'd2, 32'hFFFFFFFE, 1'b0, 1'b1, 4'd5},  // R5 -2.5 up
    '{80'h4000_E000000000000000, 1'b0, 2'd0, 32'h00000004, 1'b0, 1'b1, 4'd5},  // R5 3.5 near
    '{80'h3FFE_8000000000000000, 1'b0, 2'd0, 32'h00000000, 1'b0, 1'b1, 4'd11}, // R11 0.5
    '{80'h3FFE_8000000000000000, 1'b0, 2'd2, 32'h00000001, 1'b0, 1'b1, 4'd11}, // R11 0.5 up
    '{80'h3FFE_C000000000000000, 1'b0, 2'd0, 32'h00000001, 1'b0, 1'b1, 4'd11}, // R11 0.75
    '{80'hBFFD_8000000000000000, 1'b0, 2'd1, 32'h0000FFFF, 1'b0, 1'b1, 4'd11}, // R11 -0.25 down
    '{80'h0000_0000000000000000, 1'b0, 2'd0, 32'h00000000, 1'b0, 1'b0, 4'd11}, // R11 +0
    '{80'h8000_0000000000000000, 1'b1, 2'd1, 32'h00000000, 1'b0, 1'b0, 4'd11}, // R11 -0
    '{80'h0000_0000000000000001, 1'b1, 2'd2, 32'h00000001, 1'b0, 1'b1, 4'd11}, // R11 denormal
    '{80'h8000_0000000000000001, 1'b1, 2'd1, 32'hFFFFFFFF, 1'b0, 1'b1, 4'd11}, // R11 -denormal
    '{80'h7FFF_C000000000000000, 1'b1, 2'd0, 32'h80000000, 1'b1, 1'b0, 4'd7},  // R7 NaN
    '{80'h7FFF_8000000000000000, 1'b0, 2'd0, 32'h00008000, 1'b1, 1'b0, 4'd7},  // R7 +inf
    '{80'h4005_4000000000000000, 1'b1, 2'd0, 32'h80000000, 1'b1, 1'b0, 4'd7},  // R7 unnormal
    '{80'h400D_FFFF000000000000, 1'b0, 2'd0, 32'h00008000, 1'b1, 1'b0, 4'd6},  // R6 32767.5
    '{80'h400D_FFFF000000000000, 1'b0, 2'd3, 32'h00007FFF, 1'b0, 1'b1, 4'd8},  // R8 inexact
    '{80'h7FFE_8000000000000000, 1'b1, 2'd3, 32'h80000000, 1'b1, 1'b0, 4'd3},  // R3 huge
    '{80'hFFFF_8000000000000000, 1'b1, 2'd0, 32'h80000000, 1'b1, 1'b0, 4'd7}   // R7 -inf
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic convert(input logic [79:0] op, input logic sz, input logic [1:0] rm,
                         input logic clr);
    @(negedge clk);
    req_valid  = 1'b1;
    operand    = op;
    size32     = sz;
    rnd_mode   = rm;
    flag_clear = clr;
    @(negedge clk);
    req_valid  = 1'b0;
    flag_clear = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 res_valid", {31'b0, res_valid}, 32'h0);
    chk("R1 status", {16'b0, status}, 32'h0);
    chk("R1 ready", {31'b0, req_ready}, 32'h1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      convert(VEC[i].op, VEC[i].sz, VEC[i].rm, 1'b1);
      chk({tag, " valid"}, {31'b0, res_valid}, 32'h1);
      chk({tag, " result"}, result, VEC[i].res);
      chk({tag, " status"}, {16'b0, status},
          32'(VEC[i].ie) | (32'(VEC[i].pe) << 5));
    end

    // R9 sticky accumulation and clear
    convert(80'h4000_A000000000000000, 1'b0, 2'd0, 1'b1);
    convert(80'h7FFF_C000000000000000, 1'b0, 2'd0, 1'b0);
    chk("R9 sticky", {16'b0, status}, 32'h21);
    convert(80'h3FFF_8000000000000000, 1'b0, 2'd0, 1'b0);
    chk("R9 exact keeps flags", {16'b0, status}, 32'h21);
    @(negedge clk);
    flag_clear = 1'b1;
    @(negedge clk);
    flag_clear = 1'b0;
    chk("R9 clear", {16'b0, status}, 32'h0);

    // R10 stall handling
    res_ready = 1'b0;
    convert(80'h3FFF_8000000000000000, 1'b1, 2'd0, 1'b0);
    chk("R10 first valid", {31'b0, res_valid}, 32'h1);
    req_valid = 1'b1;
    operand   = 80'h4005_C800000000000000;
    #0;
    chk("R10 ready low", {31'b0, req_ready}, 32'h0);
    @(negedge clk);
    chk("R10 held result", result, 32'h00000001);
    chk("R10 held valid", {31'b0, res_valid}, 32'h1);
    res_ready = 1'b1;
    #0;
    chk("R10 ready via consumer", {31'b0, req_ready}, 32'h1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 next result", result, 32'h00000064);
    @(negedge clk);
    chk("R10 drained", {31'b0, res_valid}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule